// File: doc/BRIEF.md
# Load/Store Alignment Guard

This block sits between the execute stage of a 32-bit processor and its data memory port. Each cycle it may receive one load or store request. A request carries an address, an access width (byte, halfword or word), a direction, a signedness flag for loads, a flag marking the left/right partial-word variants, and a destination register index. The block tests the address for natural alignment for that width. A request that passes goes to memory in the same cycle. A request that fails is held back from memory and becomes an address-error exception request, with the offending address kept.

Load data comes back from a synchronous memory one cycle after the request. The block picks the addressed byte or halfword lane (little-endian) and widens it to 32 bits, with sign extension or zero extension as requested. It then presents the result, with its destination index, as a registered write-back. A faulting load never produces a write-back, and a faulting store never reaches the memory port.

Top module: `lsu_align_guard`

## Requirements
- R1: A byte access (`req_size` = 0) is never misaligned; it reaches memory at every address offset.
- R2: A halfword access (`req_size` = 1) is misaligned exactly when address bit 0 is 1.
- R3: A word access (`req_size` = 2 or 3) is misaligned when address bits 1:0 are anything other than 00.
- R4: A partial-word access (`req_part` = 1) is never misaligned, and its `mem_addr` has bits 1:0 forced to 00.
- R5: A misaligned request keeps `mem_valid` low in the same cycle it is presented.
- R6: In the cycle after a misaligned request, `exc_valid` is 1 for one cycle. `exc_code` is 4 for a load (`req_write` = 0) and 5 for a store (`req_write` = 1).
- R7: From the cycle after a misaligned request, `bad_vaddr` holds that request's full address, and keeps it until the next misaligned request.
- R8: A misaligned load never produces `ld_valid`. An aligned load produces `ld_valid` with its `req_dest` on `ld_dest` two cycles after the request (memory returns `mem_rdata` one cycle after the request).
- R9: A signed byte or halfword load (`req_signed` = 1) sign-extends the lane that starts at bit 8 x addr[1:0] (byte) or at bit 16 x addr[1] (halfword) of `mem_rdata`.
- R10: An unsigned byte or halfword load zero-extends that same lane. Word and partial-word loads return `mem_rdata` unchanged.
- R11: An aligned request drives `mem_valid` = 1 in the same cycle, with `mem_write`, `mem_size` and `mem_wdata` equal to the request's, and `mem_addr` equal to `req_addr` for non-partial requests.
- R12: While reset is high, and in the first cycle after it, `exc_valid` and `ld_valid` are 0 and `bad_vaddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_signed | input | 1 | Sign-extend a narrow load |
| req_part | input | 1 | Left/right partial-word access |
| req_addr | input | 32 | Virtual address |
| req_wdata | input | 32 | Store data |
| req_dest | input | 5 | Load destination register |
| mem_valid | output | 1 | Memory request, gated by the fault |
| mem_write | output | 1 | Memory write strobe qualifier |
| mem_size | output | 2 | Access width to memory |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read word, one cycle after the request |
| ld_valid | output | 1 | Register write-back enable |
| ld_data | output | 32 | Extended load result |
| ld_dest | output | 5 | Write-back register index |
| exc_valid | output | 1 | Address-error exception request |
| exc_code | output | 5 | 4 load error, 5 store error |
| bad_vaddr | output | 32 | Last faulting address |

## Verification
The bench drives every width at all four address offsets, in both directions and with both signedness settings. A design that tested the wrong bit for halfwords, or only bit 0 for words, would show up as a `mem_valid` or `exc_valid` mismatch. Partial-word requests at odd addresses catch a guard that faults on them or fails to clear the low address bits. A faulting store that leaks `mem_valid` fails R5 within the same cycle, and swapped load and store codes fail R6. Back-to-back faults followed by aligned traffic show whether `bad_vaddr` is overwritten or held correctly. Loads chosen so that the selected lane has its top bit set expose a wrong lane or a wrong extension.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WALT = 2'd3
  } acc_size_e;

  localparam int EXC_W = 5;
  localparam logic [EXC_W-1:0] EXC_ADDR_LOAD  = 5'd4;
  localparam logic [EXC_W-1:0] EXC_ADDR_STORE = 5'd5;
endpackage

// File: rtl/lsu_align_detect.sv
module lsu_align_detect
  import lsu_align_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  logic [1:0]       size,
  input  logic             part,
  input  logic [OFF_W-1:0] off,
  output logic             misaligned
);
  always_comb begin
    misaligned = 1'b0;
    if (!part) begin
      unique case (acc_size_e'(size))
        SZ_BYTE: misaligned = 1'b0;
        SZ_HALF: misaligned = off[0];
        default: misaligned = |off;
      endcase
    end
  end
endmodule

// File: rtl/lsu_fault_capture.sv
module lsu_fault_capture
  import lsu_align_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fault,
  input  logic              is_store,
  input  logic [ADDR_W-1:0] addr,
  output logic              exc_valid,
  output logic [EXC_W-1:0]  exc_code,
  output logic [ADDR_W-1:0] bad_vaddr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      exc_valid <= 1'b0;
      exc_code  <= '0;
      bad_vaddr <= '0;
    end else begin
      exc_valid <= fault;
      if (fault) begin
        exc_code  <= is_store ? EXC_ADDR_STORE : EXC_ADDR_LOAD;
        bad_vaddr <= addr;
      end
    end
  end
endmodule

// File: rtl/lsu_load_format.sv
module lsu_load_format
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 2,
  parameter int REG_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic [1:0]        size,
  input  logic              sign,
  input  logic              part,
  input  logic [OFF_W-1:0]  off,
  input  logic [REG_W-1:0]  dest,
  input  logic [DATA_W-1:0] rdata,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data,
  output logic [REG_W-1:0]  ld_dest
);
  localparam int SH_W = OFF_W + 3;

  logic              p_valid;
  logic [1:0]        p_size;
  logic              p_sign;
  logic              p_part;
  logic [OFF_W-1:0]  p_off;
  logic [REG_W-1:0]  p_dest;

  logic [DATA_W-1:0] lane_word;
  logic [DATA_W-1:0] shaped;
  logic [7:0]        b_v;
  logic [15:0]       h_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_valid <= 1'b0;
      p_size  <= '0;
      p_sign  <= 1'b0;
      p_part  <= 1'b0;
      p_off   <= '0;
      p_dest  <= '0;
    end else begin
      p_valid <= issue;
      if (issue) begin
        p_size <= size;
        p_sign <= sign;
        p_part <= part;
        p_off  <= off;
        p_dest <= dest;
      end
    end
  end

  always_comb begin
    lane_word = rdata >> SH_W'({p_off, 3'b000});
    b_v = lane_word[7:0];
    h_v = lane_word[15:0];
    if (p_part) begin
      shaped = rdata;
    end else begin
      unique case (acc_size_e'(p_size))
        SZ_BYTE: shaped = {{(DATA_W-8){p_sign & b_v[7]}}, b_v};
        SZ_HALF: shaped = {{(DATA_W-16){p_sign & h_v[15]}}, h_v};
        default: shaped = rdata;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_valid <= 1'b0;
      ld_data  <= '0;
      ld_dest  <= '0;
    end else begin
      ld_valid <= p_valid;
      if (p_valid) begin
        ld_data <= shaped;
        ld_dest <= p_dest;
      end
    end
  end
endmodule

// File: rtl/lsu_align_guard.sv
module lsu_align_guard
  import lsu_align_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int REG_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  input  logic              req_part,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [REG_W-1:0]  req_dest,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [1:0]        mem_size,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data,
  output logic [REG_W-1:0]  ld_dest,
  output logic              exc_valid,
  output logic [4:0]        exc_code,
  output logic [ADDR_W-1:0] bad_vaddr
);
  localparam int OFF_W = $clog2(DATA_W / 8);

  logic misaligned;
  logic fault;
  logic issue_ld;

  lsu_align_detect #(.OFF_W(OFF_W)) u_detect (
    .size       (req_size),
    .part       (req_part),
    .off        (req_addr[OFF_W-1:0]),
    .misaligned (misaligned)
  );

  assign fault     = req_valid & misaligned;
  assign mem_valid = req_valid & ~misaligned;
  assign mem_write = req_write;
  assign mem_size  = req_size;
  assign mem_wdata = req_wdata;
  assign mem_addr  = req_part ? {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}} : req_addr;
  assign issue_ld  = mem_valid & ~req_write;

  lsu_fault_capture #(.ADDR_W(ADDR_W)) u_fault (
    .clk       (clk),
    .rst       (rst),
    .fault     (fault),
    .is_store  (req_write),
    .addr      (req_addr),
    .exc_valid (exc_valid),
    .exc_code  (exc_code),
    .bad_vaddr (bad_vaddr)
  );

  lsu_load_format #(.DATA_W(DATA_W), .OFF_W(OFF_W), .REG_W(REG_W)) u_fmt (
    .clk      (clk),
    .rst      (rst),
    .issue    (issue_ld),
    .size     (req_size),
    .sign     (req_signed),
    .part     (req_part),
    .off      (req_addr[OFF_W-1:0]),
    .dest     (req_dest),
    .rdata    (mem_rdata),
    .ld_valid (ld_valid),
    .ld_data  (ld_data),
    .ld_dest  (ld_dest)
  );
endmodule

// File: rtl/lsu_align_guard_chk.sv
module lsu_align_guard_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int REG_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [1:0]        req_size,
  input logic              req_signed,
  input logic              req_part,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic [REG_W-1:0]  req_dest,
  input logic              mem_valid,
  input logic              mem_write,
  input logic [1:0]        mem_size,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [DATA_W-1:0] mem_rdata,
  input logic              ld_valid,
  input logic [DATA_W-1:0] ld_data,
  input logic [REG_W-1:0]  ld_dest,
  input logic              exc_valid,
  input logic [4:0]        exc_code,
  input logic [ADDR_W-1:0] bad_vaddr
);
  logic bad_req;
  always_comb begin
    bad_req = 1'b0;
    if (req_valid && !req_part) begin
      if (req_size == 2'd1) bad_req = req_addr[0];
      else if (req_size[1]) bad_req = (req_addr[1:0] != 2'b00);
    end
  end

  a_r1_byte_passes: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_size == 2'd0) |-> mem_valid);

  a_r4_part_word_addr: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_part) |-> (mem_valid && mem_addr[1:0] == 2'b00));

  a_r5_fault_gates_mem: assert property (@(posedge clk) disable iff (rst)
    bad_req |-> !mem_valid);

  a_r6_load_code: assert property (@(posedge clk) disable iff (rst)
    (bad_req && !req_write) |=> (exc_valid && exc_code == 5'd4));

  a_r6_store_code: assert property (@(posedge clk) disable iff (rst)
    (bad_req && req_write) |=> (exc_valid && exc_code == 5'd5));

  a_r7_bad_addr: assert property (@(posedge clk) disable iff (rst)
    bad_req |=> (bad_vaddr == $past(req_addr)));

  a_r7_bad_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (!bad_req && !$past(rst)) |=> $stable(bad_vaddr));

  a_r8_no_writeback: assert property (@(posedge clk) disable iff (rst)
    (bad_req && !req_write) |=> ##1 !ld_valid);
endmodule

bind lsu_align_guard lsu_align_guard_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W)
) u_chk (.*);

// File: tb/tb_lsu_align_guard.sv
module tb_lsu_align_guard;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 0, req_write = 0, req_signed = 0, req_part = 0;
  logic [1:0]  req_size = 0;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic [4:0]  req_dest = 0;
  logic        mem_valid, mem_write;
  logic [1:0]  mem_size;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = 0;
  logic        ld_valid, exc_valid;
  logic [31:0] ld_data, bad_vaddr;
  logic [4:0]  ld_dest, exc_code;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsu_align_guard dut (.*);

  function automatic logic [31:0] pat(input logic [31:0] wa);
    return {wa[31:2], 2'b00} ^ 32'h8A7F_3C91;
  endfunction

  // memory model: synchronous read, one cycle latency
  always_ff @(posedge clk) begin
    if (mem_valid && !mem_write) mem_rdata <= pat(mem_addr);
  end

  // reference model state
  logic        e_exc = 0;
  logic [4:0]  e_code = 0;
  logic [31:0] e_bad = 0;
  logic        e_ldv = 0, p_ldv = 0;
  logic [31:0] e_ldd = 0, p_ldd = 0;
  logic [4:0]  e_ldr = 0, p_ldr = 0;
  string       e_tag = "R10", p_tag = "R10";

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit model_bad(input logic [1:0] sz, input logic pt, input logic [31:0] a);
    if (pt) return 0;
    if (sz == 2'd0) return 0;
    if (sz == 2'd1) return a[0];
    return a[1:0] != 2'b00;
  endfunction

  function automatic logic [31:0] model_ext(input logic [1:0] sz, input logic sg, input logic pt,
                                           input logic [31:0] a, input logic [31:0] w);
    logic [7:0]  b;
    logic [15:0] h;
    b = w[8*a[1:0] +: 8];
    h = a[1] ? w[31:16] : w[15:0];
    if (pt || sz[1]) return w;
    if (sz == 2'd0) return sg ? {{24{b[7]}}, b} : {24'd0, b};
    return sg ? {{16{h[15]}}, h} : {16'd0, h};
  endfunction

  task automatic step(input logic v, input logic w, input logic [1:0] sz, input logic sg,
                      input logic pt, input logic [31:0] a, input logic [4:0] d);
    bit bad;
    string st;
    @(negedge clk);
    // registered outputs for this cycle
    chk(exc_valid === e_exc, "R6", 32'(exc_valid), 32'(e_exc));
    if (e_exc) chk(exc_code === e_code, "R6", 32'(exc_code), 32'(e_code));
    chk(bad_vaddr === e_bad, "R7", bad_vaddr, e_bad);
    chk(ld_valid === e_ldv, "R8", 32'(ld_valid), 32'(e_ldv));
    if (e_ldv) begin
      chk(ld_data === e_ldd, e_tag, ld_data, e_ldd);
      chk(ld_dest === e_ldr, "R8", 32'(ld_dest), 32'(e_ldr));
    end
    // drive new request
    req_valid = v; req_write = w; req_size = sz; req_signed = sg;
    req_part = pt; req_addr = a; req_dest = d; req_wdata = ~a;
    #1;
    bad = v && model_bad(sz, pt, a);
    if (pt) st = "R4";
    else if (sz == 2'd0) st = "R1";
    else if (sz == 2'd1) st = "R2";
    else st = "R3";
    if (bad) st = {st, "/R5"};
    chk(mem_valid === (v && !bad), st, 32'(mem_valid), 32'(v && !bad));
    if (v && !bad) begin
      chk(mem_addr === (pt ? {a[31:2], 2'b00} : a), pt ? "R4" : "R11", mem_addr,
          pt ? {a[31:2], 2'b00} : a);
      chk(mem_write === w && mem_size === sz && mem_wdata === ~a, "R11",
          {mem_wdata[29:0], mem_size}, {~a[29:0], sz});
    end
    // advance model
    e_ldv = p_ldv; e_ldd = p_ldd; e_ldr = p_ldr; e_tag = p_tag;
    p_ldv = v && !bad && !w;
    p_ldd = model_ext(sz, sg, pt, a, pat(a));
    p_ldr = d;
    p_tag = (!pt && !sz[1] && sg) ? "R9" : "R10";
    e_exc = bad;
    if (bad) begin
      e_code = w ? 5'd5 : 5'd4;
      e_bad = a;
    end
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 32'h0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 during reset
    chk(exc_valid === 0 && ld_valid === 0, "R12", 32'({exc_valid, ld_valid}), 0);
    chk(bad_vaddr === 0, "R12", bad_vaddr, 0);
    rst = 0;
    idle(); // R12: first cycle after reset checked against zeroed model

    // R1: bytes at every offset, signed and unsigned loads, stores
    for (int o = 0; o < 4; o++) begin
      step(1, 0, 0, 1, 0, 32'h1000_0040 + o, 5'(o + 1));
      step(1, 0, 0, 0, 0, 32'h2000_0080 + o, 5'(o + 5));
      step(1, 1, 0, 0, 0, 32'h3000_0000 + o, 0);
    end
    // R2: halfwords at every offset
    for (int o = 0; o < 4; o++) begin
      step(1, 0, 1, 1, 0, 32'h4000_0100 + o, 5'(o + 9));
      step(1, 0, 1, 0, 0, 32'h4000_0200 + o, 5'(o + 13));
      step(1, 1, 1, 0, 0, 32'h5000_0300 + o, 0);
    end
    // R3: words, both size encodings
    for (int o = 0; o < 4; o++) begin
      step(1, 0, 2, 0, 0, 32'h6000_0400 + o, 5'(o + 17));
      step(1, 1, 3, 0, 0, 32'h7000_0500 + o, 0);
    end
    // R4: partial-word at odd addresses
    for (int o = 0; o < 4; o++) begin
      step(1, 0, 2, 0, 1, 32'h8000_0600 + o, 5'(o + 21));
      step(1, 1, 2, 0, 1, 32'h9000_0700 + o, 0);
    end
    // R7: back-to-back faults then held value through aligned traffic
    step(1, 1, 2, 0, 0, 32'hDEAD_BEE1, 0);
    step(1, 0, 1, 0, 0, 32'hCAFE_F00D, 3);
    step(1, 0, 2, 0, 0, 32'h0000_1230, 4);
    step(1, 1, 0, 0, 0, 32'h0000_1233, 0);
    idle(); idle();
    // mixed pseudo-random traffic
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] | r[1], r[2], r[4:3], r[5], (r[7:6] == 2'b11), $urandom, 5'(r[12:8]));
    end
    idle(); idle(); idle();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule